// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the eight status and mode flags of a small 8-bit processor core. Instruction decode drives it with explicit set and clear strobes for each flag. The arithmetic unit drives it with per-flag update enables and new values, plus two shortcuts. One shortcut derives zero and negative from a result byte. The other copies bit 6 of a bit-test operand into overflow. A pull from the stack replaces the whole register in one cycle.

When the core accepts an interrupt, the block sets interrupt disable at once. It also offers the byte to be pushed, with the break position filled in according to whether the interrupt came from a software break.

The flags leave the block as one byte. The push image is a combinational view of that byte, so the sequencer can write it to the stack in the same cycle the interrupt is accepted.

Top module: `psr_core`

## Requirements
- R1: After reset, flag bit 2 (interrupt disable) reads 1. No other flag bit has a defined reset value.
- R2: Flag positions, counted from bit 0 upward, are: carry, zero, interrupt disable, decimal, break, memory-operation mode, overflow, negative.
- R3: While `irq_take` is high at a clock edge, interrupt disable (bit 2) becomes 1 and break (bit 4) takes the value of `irq_brk`. This holds whatever other request is present in that cycle.
- R4: `push_byte` equals `flags`, except that bit 4 equals `irq_brk` while `irq_take` is high.
- R5: A `set_strb` bit sets its flag only at bits 0, 2, 3 and 5. At bits 1, 4, 6 and 7 it has no effect.
- R6: A `clr_strb` bit clears its flag only at bits 0, 2, 3, 5 and 6. At bits 1, 4 and 7 it has no effect.
- R7: When set and clear strobes hit the same flag in one cycle, the set wins. Either strobe wins over an arithmetic update of that flag.
- R8: With `zn_en` high, bit 1 becomes 1 if `zn_res` is 0 and becomes 0 otherwise, and bit 7 copies bit 7 of `zn_res`.
- R9: With `bt_en` high, bit 6 copies bit 6 of `bt_op`.
- R10: Each bit with `upd_en` high loads the matching `upd_val` bit. The zero/negative and bit-test shortcuts override `upd_val` on the bits they drive.
- R11: With `stk_load` high, all eight flags take `stk_data` in one cycle. This beats strobes and updates but not R3.
- R12: In a cycle with no request, every flag holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_take | input | 1 | Interrupt accepted this cycle |
| irq_brk | input | 1 | Accepted interrupt is a software break |
| stk_load | input | 1 | Load all flags from the stack byte |
| stk_data | input | 8 | Byte pulled from the stack |
| set_strb | input | 8 | Per-flag set strobes |
| clr_strb | input | 8 | Per-flag clear strobes |
| upd_en | input | 8 | Per-flag arithmetic update enables |
| upd_val | input | 8 | New flag values from the arithmetic unit |
| zn_en | input | 1 | Derive zero and negative from `zn_res` |
| zn_res | input | 8 | Result byte for zero/negative |
| bt_en | input | 1 | Bit-test: copy operand bit 6 to overflow |
| bt_op | input | 8 | Bit-test operand |
| flags | output | 8 | Current flag register |
| push_byte | output | 8 | Byte to push to the stack |

## Verification
The bench builds the block with its default parameters. These are a two-stage reset release, the set mask on carry, interrupt disable, decimal and mode, and the clear mask that adds overflow. The masks therefore cover every flag in three ways: flags both strobes reach, flags only the clear strobe reaches, and flags no strobe reaches. Directed cycles collide interrupt accept, stack load, strobes and arithmetic updates on the same flag. Sparse random traffic then stacks these sources in mixed combinations. Flag bits are compared only once something has written them, because their reset values are undefined.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int PSR_W = 8;
  localparam int BIT_C = 0;
  localparam int BIT_Z = 1;
  localparam int BIT_I = 2;
  localparam int BIT_D = 3;
  localparam int BIT_B = 4;
  localparam int BIT_T = 5;
  localparam int BIT_V = 6;
  localparam int BIT_N = 7;
  typedef logic [PSR_W-1:0] psr_t;
  localparam psr_t SET_OK  = 8'b0010_1101;
  localparam psr_t CLR_OK  = 8'b0110_1101;
  localparam psr_t RST_IMG = 8'b0000_0100;
endpackage

// File: rtl/psr_rst_sync.sv
module psr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/psr_flag_cell.sv
module psr_flag_cell #(
  parameter bit HAS_SET = 1'b1,
  parameter bit HAS_CLR = 1'b1,
  parameter bit RST_BIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic force_i,
  input  logic force_val_i,
  input  logic ld_i,
  input  logic ld_val_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic upd_i,
  input  logic upd_val_i,
  output logic q_o
);
  logic q_q;
  logic q_d;
  logic q_en;
  logic set_eff;
  logic clr_eff;

  assign set_eff = set_i & HAS_SET;
  assign clr_eff = clr_i & HAS_CLR;

  // priority: interrupt force, stack load, set, clear, arithmetic update
  always_comb begin
    q_d  = q_q;
    q_en = force_i | ld_i | set_eff | clr_eff | upd_i;
    if (force_i)      q_d = force_val_i;
    else if (ld_i)    q_d = ld_val_i;
    else if (set_eff) q_d = 1'b1;
    else if (clr_eff) q_d = 1'b0;
    else if (upd_i)   q_d = upd_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_q <= RST_BIT;
    else if (q_en) q_q <= q_d;
  end

  assign q_o = q_q;

  generate
    if (HAS_SET) begin : g_set_chk
      assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !force_i && !ld_i) |=> q_o);
    end
    if (HAS_CLR) begin : g_clr_chk
      assert_clr_takes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_eff && !force_i && !ld_i) |=> !q_o);
    end
  endgenerate

  // R5 and R6: strobes outside the masks leave the bit alone
  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(force_i || ld_i || set_eff || clr_eff || upd_i) |=> $stable(q_o));
endmodule

// File: rtl/psr_upd_merge.sv
module psr_upd_merge
  import psr_pkg::*;
(
  input  psr_t       upd_en,
  input  psr_t       upd_val,
  input  logic       zn_en,
  input  logic [7:0] zn_res,
  input  logic       bt_en,
  input  logic [7:0] bt_op,
  output psr_t       en_o,
  output psr_t       val_o
);
  always_comb begin
    en_o  = upd_en;
    val_o = upd_val;
    if (zn_en) begin
      en_o[BIT_Z]  = 1'b1;
      val_o[BIT_Z] = ~|zn_res;
      en_o[BIT_N]  = 1'b1;
      val_o[BIT_N] = zn_res[7];
    end
    if (bt_en) begin
      en_o[BIT_V]  = 1'b1;
      val_o[BIT_V] = bt_op[6];
    end
  end
endmodule

// File: rtl/psr_push_image.sv
module psr_push_image
  import psr_pkg::*;
(
  input  psr_t flags_i,
  input  logic irq_take,
  input  logic irq_brk,
  output psr_t push_o
);
  always_comb begin
    push_o = flags_i;
    if (irq_take) push_o[BIT_B] = irq_brk;
  end
endmodule

// File: rtl/psr_core.sv
module psr_core
  import psr_pkg::*;
#(
  parameter int   SYNC_STAGES = 2,
  parameter psr_t SET_MASK    = SET_OK,
  parameter psr_t CLR_MASK    = CLR_OK
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       irq_take,
  input  logic       irq_brk,
  input  logic       stk_load,
  input  logic [7:0] stk_data,
  input  logic [7:0] set_strb,
  input  logic [7:0] clr_strb,
  input  logic [7:0] upd_en,
  input  logic [7:0] upd_val,
  input  logic       zn_en,
  input  logic [7:0] zn_res,
  input  logic       bt_en,
  input  logic [7:0] bt_op,
  output logic [7:0] flags,
  output logic [7:0] push_byte
);
  logic rst_n_s;
  psr_t mrg_en;
  psr_t mrg_val;
  psr_t flg;

  psr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_o(rst_n_s)
  );

  psr_upd_merge u_merge (
    .upd_en(upd_en), .upd_val(upd_val), .zn_en(zn_en), .zn_res(zn_res),
    .bt_en(bt_en), .bt_op(bt_op), .en_o(mrg_en), .val_o(mrg_val)
  );

  generate
    for (genvar i = 0; i < PSR_W; i++) begin : g_flag
      localparam bit IS_FORCED = (i == BIT_I) || (i == BIT_B);
      logic frc;
      logic frc_val;
      assign frc     = irq_take & IS_FORCED;
      assign frc_val = (i == BIT_I) ? 1'b1 : irq_brk;
      psr_flag_cell #(
        .HAS_SET(SET_MASK[i]), .HAS_CLR(CLR_MASK[i]), .RST_BIT(RST_IMG[i])
      ) u_cell (
        .clk(clk), .rst_n(rst_n_s),
        .force_i(frc), .force_val_i(frc_val),
        .ld_i(stk_load), .ld_val_i(stk_data[i]),
        .set_i(set_strb[i]), .clr_i(clr_strb[i]),
        .upd_i(mrg_en[i]), .upd_val_i(mrg_val[i]),
        .q_o(flg[i])
      );
    end
  endgenerate

  psr_push_image u_push (
    .flags_i(flg), .irq_take(irq_take), .irq_brk(irq_brk), .push_o(push_byte)
  );

  assign flags = flg;

  assert_irq_masks_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_take |=> (flags[BIT_I] && flags[BIT_B] == $past(irq_brk)));

  assert_stack_load_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (stk_load && !irq_take) |=> flags == $past(stk_data));

  assert_zero_neg_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (zn_en && !stk_load) |=>
      (flags[BIT_Z] == ($past(zn_res) == 8'd0) && flags[BIT_N] == $past(zn_res[7])));

  assert_bit_test_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bt_en && !stk_load && !clr_strb[BIT_V]) |=> flags[BIT_V] == $past(bt_op[6]));

  assert_push_plain_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    !irq_take |-> push_byte == flags);
endmodule

// File: tb/test_psr_core.sv
module test_psr_core;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       irq_take, irq_brk, stk_load, zn_en, bt_en;
  logic [7:0] stk_data, set_strb, clr_strb, upd_en, upd_val, zn_res, bt_op;
  logic [7:0] flags, push_byte;

  logic [7:0] ref_f;
  logic [7:0] known;
  int checks = 0;
  int fails  = 0;

  localparam logic [7:0] SM = 8'b0010_1101;
  localparam logic [7:0] CM = 8'b0110_1101;

  always #5 clk = ~clk;

  psr_core i_psr_core (
    .clk(clk), .rst_n(rst_n), .irq_take(irq_take), .irq_brk(irq_brk),
    .stk_load(stk_load), .stk_data(stk_data), .set_strb(set_strb),
    .clr_strb(clr_strb), .upd_en(upd_en), .upd_val(upd_val), .zn_en(zn_en),
    .zn_res(zn_res), .bt_en(bt_en), .bt_op(bt_op), .flags(flags),
    .push_byte(push_byte)
  );

  task automatic chk(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp, input logic [7:0] m);
    checks++;
    if (((act ^ exp) & m) != 8'h00) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h (mask %h)", tag, what, act, exp, m);
    end
  endtask

  task automatic idle();
    irq_take = 0; irq_brk = 0; stk_load = 0; stk_data = 0;
    set_strb = 0; clr_strb = 0; upd_en = 0; upd_val = 0;
    zn_en = 0; zn_res = 0; bt_en = 0; bt_op = 0;
  endtask

  // behavioural reference: next flag byte from current inputs
  task automatic ref_step();
    logic [7:0] t;
    t = ref_f;
    for (int b = 0; b < 8; b++) if (upd_en[b]) begin t[b] = upd_val[b]; known[b] = 1; end
    if (zn_en) begin t[1] = (zn_res == 0); t[7] = zn_res[7]; known[1] = 1; known[7] = 1; end
    if (bt_en) begin t[6] = bt_op[6]; known[6] = 1; end
    t = t & ~(clr_strb & CM);
    t = t | (set_strb & SM);
    known = known | ((clr_strb & CM) | (set_strb & SM));
    if (stk_load) begin t = stk_data; known = 8'hFF; end
    if (irq_take) begin t[2] = 1; t[4] = irq_brk; known[2] = 1; known[4] = 1; end
    ref_f = t;
  endtask

  task automatic cyc(input string tag);
    logic [7:0] ep;
    logic [7:0] pm;
    #1;
    ep = ref_f; pm = known;
    if (irq_take) begin ep[4] = irq_brk; pm[4] = 1; end
    chk(tag, "push_byte", push_byte, ep, pm);
    @(posedge clk);
    ref_step();
    @(negedge clk);
    chk(tag, "flags", flags, ref_f, known);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R12 watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    ref_f = 8'h04; known = 8'h04;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1", "flags after reset", flags, 8'h04, 8'h04);

    // R11 full load
    stk_load = 1; stk_data = 8'hA5; cyc("R11"); idle();
    // R5 set strobes on all bits from zero
    stk_load = 1; stk_data = 8'h00; cyc("R11"); idle();
    set_strb = 8'hFF; cyc("R5"); idle();
    chk("R5", "set image", flags, 8'h2D, 8'hFF);
    // R6 clear strobes on all bits from ones
    stk_load = 1; stk_data = 8'hFF; cyc("R11"); idle();
    clr_strb = 8'hFF; cyc("R6"); idle();
    chk("R6", "clear image", flags, 8'h92, 8'hFF);
    // R7 set and clear and update collide on carry
    set_strb = 8'h01; clr_strb = 8'h01; upd_en = 8'h01; upd_val = 8'h00; cyc("R7"); idle();
    chk("R7", "carry", flags, 8'h01, 8'h01);
    clr_strb = 8'h08; upd_en = 8'h08; upd_val = 8'h08; cyc("R7"); idle();
    chk("R7", "decimal", flags, 8'h00, 8'h08);
    // R8 zero/negative
    zn_en = 1; zn_res = 8'h00; cyc("R8"); idle();
    chk("R8", "Z=1 N=0", flags, 8'h02, 8'h82);
    zn_en = 1; zn_res = 8'h80; upd_en = 8'h82; upd_val = 8'h02; cyc("R8"); idle();
    chk("R8", "Z=0 N=1", flags, 8'h80, 8'h82);
    // R9 bit test
    bt_en = 1; bt_op = 8'h40; cyc("R9"); idle();
    chk("R9", "V=1", flags, 8'h40, 8'h40);
    bt_en = 1; bt_op = 8'hBF; cyc("R9"); idle();
    chk("R9", "V=0", flags, 8'h00, 8'h40);
    // R3 and R4 interrupt accept
    clr_strb = 8'h04; irq_take = 1; irq_brk = 0; cyc("R3"); idle();
    chk("R3", "I=1 B=0", flags, 8'h04, 8'h14);
    irq_take = 1; irq_brk = 1; #1;
    chk("R4", "push break", push_byte, 8'h10, 8'h10);
    cyc("R4"); idle();
    chk("R3", "I=1 B=1", flags, 8'h14, 8'h14);
    // R11 load under interrupt
    stk_load = 1; stk_data = 8'h00; irq_take = 1; irq_brk = 0; cyc("R11"); idle();
    chk("R11", "load with irq", flags, 8'h04, 8'hFF);
    // R12 hold
    repeat (3) cyc("R12");
    // R2 layout: decimal at bit 3, mode at bit 5
    set_strb = 8'h08; cyc("R2"); idle();
    chk("R2", "decimal position", flags, 8'h0C, 8'hFF);
    set_strb = 8'h20; cyc("R2"); idle();
    chk("R2", "mode position", flags, 8'h2C, 8'hFF);
    // R10 generic update with shortcut override
    upd_en = 8'hFF; upd_val = 8'h5A; zn_en = 1; zn_res = 8'h01; cyc("R10"); idle();
    chk("R10", "merge", flags, 8'h58, 8'hFF);

    for (int n = 0; n < 4000; n++) begin
      irq_take = ($urandom % 16) == 0;
      irq_brk  = 1'($urandom);
      stk_load = ($urandom % 12) == 0;
      stk_data = 8'($urandom);
      set_strb = 8'($urandom) & 8'($urandom);
      clr_strb = 8'($urandom) & 8'($urandom);
      upd_en   = 8'($urandom);
      upd_val  = 8'($urandom);
      zn_en    = ($urandom % 4) == 0;
      zn_res   = (($urandom % 4) == 0) ? 8'h00 : 8'($urandom);
      bt_en    = ($urandom % 4) == 0;
      bt_op    = 8'($urandom);
      cyc("R10");
    end
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule